// File: doc/BRIEF.md
# PHY Test-Port Register Bridge

This block turns single-byte register read and write requests into the bit-level handshake of a physical-layer test port. The test port has a test clock, a test enable, a test clear line, an 8-bit data input to the PHY and an 8-bit data output from the PHY. Every access starts with an address phase. In that phase the enable is high, the address is on the data input, and one test-clock pulse is given. A write then lowers the enable, drives the data byte and gives a second pulse. A read lowers the enable after the address pulse and captures the PHY's output byte. Each high and low phase of the test clock lasts a programmable number of system clocks, so that setup and hold at the PHY are met.

The same block sequences the PHY control lines. A bring-up request holds shutdown and reset asserted with the PHY clock off, and pulses test-clear low-high-low. The block then waits while software configures the PHY through the bridge. On a configuration-done strobe it releases shutdown, then reset, then enables the clock, and it watches the PLL lock flag for a bounded number of cycles. It also presents the lane-count code and the minimum stop time that the PHY wrapper needs.

Top module: `tpb_bridge`

## Requirements
- R1: After synchronous reset, `busy`, `rsp_valid`, `tp_clk`, `tp_en` and `tp_clr` are low, `phy_shdn_n`, `phy_rst_n` and `phy_clk_en` are low, and both lock flags are low.
- R2: An accepted write with address and data both at most 0xFF gives one pulse with `tp_en` high and `tp_din` equal to the address, then one pulse with `tp_en` low and `tp_din` equal to the data. The response then has `rsp_err` low.
- R3: An accepted read with address at most 0xFF gives only the address pulse. It then lowers `tp_en` and returns the captured `tp_dout` byte in `rsp_rdata`. On a read, `req_wdata` is not range-checked.
- R4: A request whose address is above 0xFF, or a write whose data is above 0xFF, causes no test-clock pulse. In the next cycle it raises `rsp_valid` and `rsp_err` with `busy` low.
- R5: Every test-clock high phase and low phase lasts L system clocks, where L is `half_period`, or 1 when `half_period` is 0. `busy` stays high for 6L cycles for a write and 4L cycles for a read.
- R6: `busy` rises in the cycle after a request is accepted. A request is accepted only when `req_valid` is high, `busy` is low and `bringup_go` is low. A request presented while `busy` is high has no effect. `rsp_valid` is a single-cycle pulse in the first cycle that `busy` is low.
- R7: While `tp_clk` stays high, `tp_din` and `tp_en` do not change.
- R8: An accepted `bringup_go` (taken only while `busy` is low) asserts shutdown and reset and turns the PHY clock off. `tp_clr` is then low for L cycles, high for L cycles and low for L cycles, and `busy` is high throughout.
- R9: After the clear pulse, a `cfg_done` strobe raises `phy_shdn_n` in the next cycle, `phy_rst_n` one cycle later and `phy_clk_en` one cycle after that.
- R10: While the clock is enabled and lock is pending, a high `phy_pll_lock` sets `pll_lock_ok` one cycle later. If lock is not seen within `LOCK_POLL` cycles, `pll_lock_fail` is set and shutdown, reset and clock are asserted again.
- R11: `phy_lane_cfg` equals the lane count minus one, and `phy_stop_time` equals 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | HP_W | Length of each test-clock phase in system clocks (0 acts as 1) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REQ_W | Register address (legal range 0 to 0xFF) |
| req_wdata | input | REQ_W | Write data (legal range 0 to 0xFF) |
| busy | output | 1 | Access or clear sequence in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected as out of range |
| rsp_rdata | output | 8 | Read data byte |
| tp_clk | output | 1 | Test-port clock |
| tp_en | output | 1 | Test-port enable (address phase) |
| tp_clr | output | 1 | Test-port clear |
| tp_din | output | 8 | Byte driven into the test port |
| tp_dout | input | 8 | Byte returned by the test port |
| bringup_go | input | 1 | Start PHY bring-up |
| cfg_done | input | 1 | Configuration finished, start release |
| phy_pll_lock | input | 1 | PLL lock flag from the PHY status |
| phy_shdn_n | output | 1 | PHY shutdown, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| phy_clk_en | output | 1 | PHY clock enable |
| pll_lock_ok | output | 1 | Lock seen within the poll window |
| pll_lock_fail | output | 1 | Lock not seen within the poll window |
| phy_lane_cfg | output | LANE_W | Lane count minus one |
| phy_stop_time | output | 8 | Minimum stop time code |

## Verification
The access path is driven with random mixes of reads and writes at random phase lengths from 0 to 15. About one request in eight is out of range. A behavioural register-file PHY latches the address while enable is high and the data while it is low. Wrong phase lengths therefore show up as busy-length and pulse-width errors, and a swapped address and data phase shows up as a corrupted register. Directed cases cover the edges of the range (0xFF accepted, 0x100 rejected), a read with out-of-range data that must still go through, and a request poked in mid-transfer that must leave the PHY untouched. The bring-up sequence is run twice. The first run gets a late lock and must end in the lock-ok state. The second run never gets lock and must fail after exactly the poll window, which separates the release order and the poll count from the clear pulse.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    localparam int TP_W   = 8;
    localparam int TP_MAX = (1 << TP_W) - 1;

    typedef enum logic [2:0] {
        AX_IDLE,
        AX_ADDR_SET,
        AX_ADDR_HI,
        AX_ADDR_LO,
        AX_DATA_SET,
        AX_DATA_HI,
        AX_DATA_LO,
        AX_READ_CAP
    } acc_state_e;

    typedef enum logic [3:0] {
        BU_HOLD,
        BU_CLR_PRE,
        BU_CLR_HI,
        BU_CLR_POST,
        BU_CFG,
        BU_REL_SD,
        BU_REL_RST,
        BU_LOCK,
        BU_UP,
        BU_FAIL
    } bu_state_e;

    typedef struct packed {
        logic            write;
        logic [TP_W-1:0] addr;
        logic [TP_W-1:0] data;
    } tp_req_t;

    // true when a request field does not fit the test-port byte
    function automatic logic over_byte(input logic [31:0] v);
        return v > 32'(TP_MAX);
    endfunction

endpackage

// File: rtl/tpb_phase_cnt.sv
module tpb_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    assign last = run && (cnt == len - W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || last) cnt <= '0;
        else                     cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/tpb_access.sv
module tpb_access
    import tpb_pkg::*;
#(
    parameter int HP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  tp_req_t         req,
    input  logic [HP_W-1:0] len,
    input  logic [TP_W-1:0] tp_dout,
    output logic            tp_clk,
    output logic            tp_en,
    output logic [TP_W-1:0] tp_din,
    output logic            acc_busy,
    output logic            acc_done,
    output logic [TP_W-1:0] acc_rdata
);
    acc_state_e st;
    tp_req_t    hold;
    logic       last;

    assign acc_busy = (st != AX_IDLE);

    tpb_phase_cnt #(.W(HP_W)) u_phase (
        .clk (clk),
        .rst (rst),
        .run (acc_busy),
        .len (len),
        .last(last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= AX_IDLE;
            hold <= '0;
        end else begin
            case (st)
                AX_IDLE:     if (start) begin hold <= req; st <= AX_ADDR_SET; end
                AX_ADDR_SET: if (last) st <= AX_ADDR_HI;
                AX_ADDR_HI:  if (last) st <= AX_ADDR_LO;
                AX_ADDR_LO:  if (last) st <= hold.write ? AX_DATA_SET : AX_READ_CAP;
                AX_DATA_SET: if (last) st <= AX_DATA_HI;
                AX_DATA_HI:  if (last) st <= AX_DATA_LO;
                AX_DATA_LO:  if (last) st <= AX_IDLE;
                AX_READ_CAP: if (last) st <= AX_IDLE;
                default:     st <= AX_IDLE;
            endcase
        end
    end

    always_comb begin
        tp_en     = (st inside {AX_ADDR_SET, AX_ADDR_HI, AX_ADDR_LO});
        tp_clk    = (st inside {AX_ADDR_HI, AX_DATA_HI});
        tp_din    = '0;
        if (tp_en)
            tp_din = hold.addr;
        else if (st inside {AX_DATA_SET, AX_DATA_HI, AX_DATA_LO})
            tp_din = hold.data;
        acc_done  = last && (st inside {AX_DATA_LO, AX_READ_CAP});
        acc_rdata = (st == AX_READ_CAP) ? tp_dout : '0;
    end
endmodule

// File: rtl/tpb_bringup.sv
module tpb_bringup
    import tpb_pkg::*;
#(
    parameter int HP_W      = 4,
    parameter int LOCK_POLL = 5000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            cfg_done,
    input  logic            lock_in,
    input  logic [HP_W-1:0] len,
    output logic            tp_clr,
    output logic            clearing,
    output logic            shdn_n,
    output logic            rst_n,
    output logic            clk_en,
    output logic            lock_ok,
    output logic            lock_fail
);
    localparam int POLL_W = $clog2(LOCK_POLL + 1);

    bu_state_e         st;
    logic [POLL_W-1:0] pcnt;
    logic              plast;

    assign clearing = (st inside {BU_CLR_PRE, BU_CLR_HI, BU_CLR_POST});

    tpb_phase_cnt #(.W(HP_W)) u_phase (
        .clk (clk),
        .rst (rst),
        .run (clearing),
        .len (len),
        .last(plast)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= BU_HOLD;
            pcnt <= '0;
        end else begin
            pcnt <= (st == BU_LOCK) ? pcnt + POLL_W'(1) : '0;
            if (go) begin
                st <= BU_CLR_PRE;
            end else begin
                case (st)
                    BU_CLR_PRE:  if (plast) st <= BU_CLR_HI;
                    BU_CLR_HI:   if (plast) st <= BU_CLR_POST;
                    BU_CLR_POST: if (plast) st <= BU_CFG;
                    BU_CFG:      if (cfg_done) st <= BU_REL_SD;
                    BU_REL_SD:   st <= BU_REL_RST;
                    BU_REL_RST:  st <= BU_LOCK;
                    BU_LOCK: begin
                        if (lock_in)                               st <= BU_UP;
                        else if (pcnt == POLL_W'(LOCK_POLL - 1))   st <= BU_FAIL;
                    end
                    default:     st <= st;
                endcase
            end
        end
    end

    always_comb begin
        tp_clr    = (st == BU_CLR_HI);
        shdn_n    = (st inside {BU_REL_SD, BU_REL_RST, BU_LOCK, BU_UP});
        rst_n     = (st inside {BU_REL_RST, BU_LOCK, BU_UP});
        clk_en    = (st inside {BU_LOCK, BU_UP});
        lock_ok   = (st == BU_UP);
        lock_fail = (st == BU_FAIL);
    end
endmodule

// File: rtl/tpb_bridge.sv
module tpb_bridge
    import tpb_pkg::*;
#(
    parameter int         REQ_W     = 10,
    parameter int         HP_W      = 4,
    parameter int         LANES     = 4,
    parameter logic [7:0] STOP_TIME = 8'h1C,
    parameter int         LOCK_POLL = 5000,
    localparam int        LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HP_W-1:0]   half_period,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [REQ_W-1:0]  req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [7:0]        rsp_rdata,
    output logic              tp_clk,
    output logic              tp_en,
    output logic              tp_clr,
    output logic [7:0]        tp_din,
    input  logic [7:0]        tp_dout,
    input  logic              bringup_go,
    input  logic              cfg_done,
    input  logic              phy_pll_lock,
    output logic              phy_shdn_n,
    output logic              phy_rst_n,
    output logic              phy_clk_en,
    output logic              pll_lock_ok,
    output logic              pll_lock_fail,
    output logic [LANE_W-1:0] phy_lane_cfg,
    output logic [7:0]        phy_stop_time
);
    logic [HP_W-1:0] len;
    logic            acc_busy, acc_done, clearing;
    logic [7:0]      acc_rdata;
    logic            go_ok, accept, req_bad;
    tp_req_t         req;

    assign len     = (half_period == '0) ? HP_W'(1) : half_period;
    assign busy    = acc_busy | clearing;
    assign go_ok   = bringup_go && !busy;
    assign accept  = req_valid && !busy && !bringup_go;
    assign req_bad = over_byte(32'(req_addr)) || (req_write && over_byte(32'(req_wdata)));
    assign req     = '{write: req_write, addr: req_addr[TP_W-1:0], data: req_wdata[TP_W-1:0]};

    tpb_access #(.HP_W(HP_W)) u_access (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && !req_bad),
        .req      (req),
        .len      (len),
        .tp_dout  (tp_dout),
        .tp_clk   (tp_clk),
        .tp_en    (tp_en),
        .tp_din   (tp_din),
        .acc_busy (acc_busy),
        .acc_done (acc_done),
        .acc_rdata(acc_rdata)
    );

    tpb_bringup #(.HP_W(HP_W), .LOCK_POLL(LOCK_POLL)) u_bringup (
        .clk      (clk),
        .rst      (rst),
        .go       (go_ok),
        .cfg_done (cfg_done),
        .lock_in  (phy_pll_lock),
        .len      (len),
        .tp_clr   (tp_clr),
        .clearing (clearing),
        .shdn_n   (phy_shdn_n),
        .rst_n    (phy_rst_n),
        .clk_en   (phy_clk_en),
        .lock_ok  (pll_lock_ok),
        .lock_fail(pll_lock_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_done || (accept && req_bad);
            rsp_err   <= accept && req_bad;
            rsp_rdata <= acc_done ? acc_rdata : '0;
        end
    end

    assign phy_lane_cfg  = LANE_W'(LANES - 1);
    assign phy_stop_time = STOP_TIME;
endmodule

// File: rtl/tpb_bridge_chk.sv
module tpb_bridge_chk #(
    parameter int REQ_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [REQ_W-1:0] req_addr,
    input logic [REQ_W-1:0] req_wdata,
    input logic             bringup_go,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             tp_clk,
    input logic             tp_en,
    input logic             tp_clr,
    input logic [7:0]       tp_din,
    input logic             phy_shdn_n,
    input logic             phy_rst_n,
    input logic             phy_clk_en,
    input logic             pll_lock_ok,
    input logic             pll_lock_fail
);
    logic bad;
    assign bad = (32'(req_addr) > 32'd255) || (req_write && (32'(req_wdata) > 32'd255));

    // R4
    reject_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !bringup_go && bad) |=> (rsp_valid && rsp_err && !busy));

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !bringup_go && !bad) |=> (busy && tp_en));

    // R6
    rsp_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |-> $fell(busy));

    // R7
    din_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tp_clk && $past(tp_clk)) |-> ($stable(tp_din) && $stable(tp_en)));

    // R8
    clr_held_chk: assert property (@(posedge clk) disable iff (rst)
        tp_clr |-> (!phy_shdn_n && !phy_rst_n && !phy_clk_en && !tp_clk && busy));

    // R9
    rst_after_sd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_rst_n) |-> (phy_shdn_n && $past(phy_shdn_n)));

    // R9
    clk_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_clk_en) |-> (phy_rst_n && $past(phy_rst_n)));

    // R10
    lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pll_lock_ok && pll_lock_fail));

    // R10
    lock_from_poll_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_lock_ok) |-> $past(phy_clk_en));
endmodule

bind tpb_bridge tpb_bridge_chk #(.REQ_W(REQ_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .bringup_go   (bringup_go),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .tp_clk       (tp_clk),
    .tp_en        (tp_en),
    .tp_clr       (tp_clr),
    .tp_din       (tp_din),
    .phy_shdn_n   (phy_shdn_n),
    .phy_rst_n    (phy_rst_n),
    .phy_clk_en   (phy_clk_en),
    .pll_lock_ok  (pll_lock_ok),
    .pll_lock_fail(pll_lock_fail)
);

// File: tb/test_tpb_bridge.sv
`timescale 1ns/1ps
module test_tpb_bridge;
    localparam int REQ_W = 10;
    localparam int HP_W  = 4;
    localparam int POLL  = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [HP_W-1:0]  half_period = '0;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [REQ_W-1:0] req_addr = '0, req_wdata = '0;
    logic             busy, rsp_valid, rsp_err;
    logic [7:0]       rsp_rdata;
    logic             tp_clk, tp_en, tp_clr;
    logic [7:0]       tp_din, tp_dout;
    logic             bringup_go = 1'b0, cfg_done = 1'b0, phy_pll_lock = 1'b0;
    logic             phy_shdn_n, phy_rst_n, phy_clk_en, pll_lock_ok, pll_lock_fail;
    logic [1:0]       phy_lane_cfg;
    logic [7:0]       phy_stop_time;

    int n_chk = 0, n_bad = 0;
    int exp_hp = 1;
    int hi_run = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tpb_bridge #(.REQ_W(REQ_W), .HP_W(HP_W), .LANES(4), .LOCK_POLL(POLL)) i_tpb_bridge (
        .clk(clk), .rst(rst), .half_period(half_period),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .tp_clk(tp_clk), .tp_en(tp_en), .tp_clr(tp_clr), .tp_din(tp_din), .tp_dout(tp_dout),
        .bringup_go(bringup_go), .cfg_done(cfg_done), .phy_pll_lock(phy_pll_lock),
        .phy_shdn_n(phy_shdn_n), .phy_rst_n(phy_rst_n), .phy_clk_en(phy_clk_en),
        .pll_lock_ok(pll_lock_ok), .pll_lock_fail(pll_lock_fail),
        .phy_lane_cfg(phy_lane_cfg), .phy_stop_time(phy_stop_time)
    );

    // behavioural PHY register file behind the test port
    logic [7:0] m_mem [256];
    logic [7:0] m_addr = '0;
    int         m_pulses = 0;
    logic [7:0] exp_mem [256];

    initial for (int i = 0; i < 256; i++) begin
        m_mem[i]   = 8'(i) ^ 8'h5A;
        exp_mem[i] = 8'(i) ^ 8'h5A;
    end

    always @(posedge tp_clk) begin
        m_pulses++;
        if (tp_en) m_addr <= tp_din;
        else       m_mem[m_addr] <= tp_din;
    end
    assign tp_dout = m_mem[m_addr];

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff(int hp);
        return (hp == 0) ? 1 : hp;
    endfunction

    // high-phase width monitor
    always @(negedge clk) begin
        if (tp_clk) hi_run++;
        else if (hi_run != 0) begin
            chk("R5 test-clock high width", hi_run, exp_hp);
            hi_run = 0;
        end
    end

    task automatic do_access(int wr, int addr, int data, int hp, bit poke);
        int p0, n;
        bit bad;
        @(negedge clk);
        half_period = HP_W'(hp);
        exp_hp      = eff(hp);
        req_valid   = 1'b1;
        req_write   = wr[0];
        req_addr    = REQ_W'(addr);
        req_wdata   = REQ_W'(data);
        p0          = m_pulses;
        bad         = (addr > 255) || (wr != 0 && data > 255);
        @(negedge clk);
        req_valid = 1'b0;
        if (bad) begin
            chk("R4 busy on reject", int'(busy), 0);
            chk("R4 rsp_valid on reject", int'(rsp_valid), 1);
            chk("R4 rsp_err on reject", int'(rsp_err), 1);
            repeat (4) @(negedge clk);
            chk("R4 no pulse on reject", m_pulses - p0, 0);
        end else begin
            n = 0;
            while (busy && n < 1000) begin
                n++;
                if (poke && n == 1) begin
                    req_valid = 1'b1; req_write = 1'b1;
                    req_addr = REQ_W'(8'h77); req_wdata = REQ_W'(8'hEE);
                end else begin
                    req_valid = 1'b0;
                end
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(wr != 0 ? "R5 write busy length" : "R5 read busy length", n, (wr != 0 ? 6 : 4) * eff(hp));
            chk("R6 rsp_valid after busy", int'(rsp_valid), 1);
            chk("R6 rsp_err clear", int'(rsp_err), 0);
            if (wr != 0) begin
                exp_mem[addr] = 8'(data);
                chk("R2 pulse count", m_pulses - p0, 2);
                chk("R2 PHY register written", int'(m_mem[addr]), data);
            end else begin
                chk("R3 pulse count", m_pulses - p0, 1);
                chk("R3 read data", int'(rsp_rdata), int'(exp_mem[addr]));
            end
            @(negedge clk);
            chk("R6 rsp_valid single cycle", int'(rsp_valid), 0);
            if (poke) begin
                repeat (3) @(negedge clk);
                chk("R6 poke ignored pulses", m_pulses - p0, wr != 0 ? 2 : 1);
                chk("R6 poke ignored register", int'(m_mem[8'h77]), int'(exp_mem[8'h77]));
            end
        end
    endtask

    task automatic bringup(int hp, bit lock_late);
        int n;
        int p0;
        @(negedge clk);
        half_period = HP_W'(hp);
        bringup_go  = 1'b1;
        phy_pll_lock = 1'b0;
        p0 = m_pulses;
        @(negedge clk);
        bringup_go = 1'b0;
        for (int i = 0; i < 3 * hp; i++) begin
            chk("R8 clear pulse shape", int'(tp_clr), (i >= hp && i < 2 * hp) ? 1 : 0);
            chk("R8 busy during clear", int'(busy), 1);
            chk("R8 held during clear", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 0);
            if (i == 1) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = REQ_W'(5); req_wdata = REQ_W'(9);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R8 busy after clear", int'(busy), 0);
        chk("R8 request refused during clear", m_pulses - p0, 0);
        chk("R8 register untouched", int'(m_mem[5]), int'(exp_mem[5]));
        do_access(1, 8'h10, 8'h3C, 2, 1'b0);
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        chk("R9 shutdown released first", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 3'b100);
        @(negedge clk);
        chk("R9 reset released second", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 3'b110);
        @(negedge clk);
        chk("R9 clock enabled third", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 3'b111);
        if (lock_late) begin
            repeat (5) @(negedge clk);
            chk("R10 no lock yet", int'(pll_lock_ok), 0);
            phy_pll_lock = 1'b1;
            @(negedge clk);
            chk("R10 lock reported", int'(pll_lock_ok), 1);
            chk("R10 no fail", int'(pll_lock_fail), 0);
            chk("R10 released after lock", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 3'b111);
        end else begin
            n = 0;
            while (phy_clk_en && n < 1000) begin
                n++;
                @(negedge clk);
            end
            chk("R10 poll window length", n, POLL);
            chk("R10 fail flag", int'(pll_lock_fail), 1);
            chk("R10 held after fail", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 0);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 test port idle", int'({tp_clk, tp_en, tp_clr}), 0);
        chk("R1 phy held", int'({phy_shdn_n, phy_rst_n, phy_clk_en}), 0);
        chk("R1 lock flags", int'({pll_lock_ok, pll_lock_fail}), 0);
        // R11 static codes
        chk("R11 lane code", int'(phy_lane_cfg), 3);
        chk("R11 stop time", int'(phy_stop_time), 8'h1C);

        bringup(3, 1'b1);

        // directed corners
        do_access(1, 8'h21, 8'hA5, 0, 1'b0);   // R5 zero half period
        do_access(0, 8'h21, 0, 1, 1'b0);
        do_access(1, 255, 255, 15, 1'b0);      // R2 top of range
        do_access(0, 255, 0, 7, 1'b0);
        do_access(1, 256, 1, 2, 1'b0);         // R4 address out of range
        do_access(1, 3, 256, 2, 1'b0);         // R4 data out of range
        do_access(0, 1023, 0, 2, 1'b0);        // R4 read address out of range
        do_access(0, 0, 1023, 2, 1'b0);        // R3 read ignores data range
        do_access(1, 8'h40, 8'h12, 3, 1'b1);   // R6 poke during write
        do_access(0, 8'h40, 0, 2, 1'b1);       // R6 poke during read

        for (int k = 0; k < 40; k++) begin
            int wr, ad, dt, hp;
            wr = int'($urandom % 2);
            ad = ($urandom % 8 == 0) ? 256 + int'($urandom % 700) : int'($urandom % 256);
            dt = ($urandom % 8 == 0) ? 256 + int'($urandom % 700) : int'($urandom % 256);
            hp = int'($urandom % 16);
            do_access(wr, ad, dt, hp, 1'b0);
        end

        bringup(2, 1'b0);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule